// File: doc/BRIEF.md
# Dual-Plane Protected Write Controller

This block sequences writes into a byte-wide nonvolatile array that is split into two equal planes. The top address bit picks the plane. Each plane has its own write sequencer, so one plane can run a long internal programming cycle while the host keeps reading the other plane. A write starts by loading bytes into a page buffer. Every byte of one load must fall in the same 32-byte page. The load ends when the host pulses an external write-control line. The plane then enters a fixed-length internal cycle, and during that cycle the buffered bytes are committed to the array one slot at a time.

The whole array is split into eight equal sections, and each section has its own write-enable bit. These bits sit in a configuration register that keeps its value through reset. A byte that falls in a locked section is never committed. While a plane is in its internal cycle, a read of that plane does not return array data. It returns a status byte whose toggle bit flips on every such read, so a host can tell when the cycle is over by polling.

Top module: `dpw_ctrl`

## Requirements
- R1: The 13-bit address splits into plane = bit 12 and in-plane offset = bits 11:0. A read request returns its answer with `rd_valid` one cycle later. An address that was never written reads as 8'hFF.
- R2: While one plane is busy, reads of the other plane return that plane's array data.
- R3: A write request to an idle plane opens a load on the page given by address bits 11:5. Later bytes for the same page go into the buffer, and if a slot is written twice the last value is kept. A byte for any other page of that plane is ignored.
- R4: A pulse on `wc` ends every open load. Busy rises in the next cycle and stays high for exactly T_PROG cycles. A single-byte write is a load that holds one byte. With no load open, `wc` has no effect.
- R5: During the busy window, the byte in buffer slot k is strobed to the array k+1 cycles after busy rises, in ascending slot order. Only loaded slots are strobed.
- R6: The section index is address bits 12:10. A byte is strobed and written only if its section's bit in the protection register is 1 at strobe time. Otherwise the array is left unchanged.
- R7: `prot_load` copies `prot_wen` into the protection register. The register starts at PROT_INIT and is not changed by `rst`.
- R8: A read of a busy plane returns a byte that has all bits 0 except bit 6, which is the plane's toggle bit. The toggle bit inverts on each such read, and the first such read after reset returns 1.
- R9: A write request to a plane that is busy is dropped. It opens no load and writes nothing.
- R10: Once busy falls, reads of that plane return the committed data.
- R11: Reset clears busy, the strobes, `rd_valid` and the toggle bits. It also discards any open load. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request: load one byte |
| wr_addr | input | 13 | Write byte address |
| wr_data | input | 8 | Write byte value |
| wc | input | 1 | Write control: ends open loads and starts the internal cycle |
| rd_req | input | 1 | Read request |
| rd_addr | input | 13 | Read byte address |
| rd_data | output | 8 | Read data or toggle status |
| rd_valid | output | 1 | rd_data holds the answer to the previous request |
| prot_load | input | 1 | Load the protection register |
| prot_wen | input | 8 | New section write-enable bits (1 = writable) |
| busy | output | 2 | Per-plane internal cycle in progress |
| arr_we | output | 2 | Per-plane array write strobe |
| arr_waddr | output | 2x13 | Per-plane strobed address |
| arr_wdata | output | 2x8 | Per-plane strobed byte |

## Verification
The bench runs several kinds of write patterns:
- A multi-byte page load that includes a repeated slot and an out-of-page byte. This separates last-value buffering from page filtering.
- A write to a locked section and a write to an open section. These show whether the lock is applied per section.
- A load into each plane closed by one shared `wc` pulse. This shows whether the two planes run independently.
- A reset in the middle of a load. This shows that reset discards the pending bytes.

Reads are placed during busy windows, to both the busy plane and the idle plane. These separate toggle polling from read-while-write. A behavioural per-cycle model checks the strobe timing and the read answers on every clock.

// File: rtl/dpw_pkg.sv
package dpw_pkg;
  typedef enum logic [1:0] {
    PL_IDLE = 2'd0,
    PL_LOAD = 2'd1,
    PL_PROG = 2'd2
  } pl_state_t;
endpackage

// File: rtl/dpw_lock.sv
// Section write-enable register; holds its content through reset to model
// nonvolatile storage of the protection configuration.
module dpw_lock #(
  parameter int SECT_N = 8,
  parameter logic [SECT_N-1:0] PROT_INIT = '1
) (
  input  logic              clk,
  input  logic              load,
  input  logic [SECT_N-1:0] wen_in,
  output logic [SECT_N-1:0] wen
);
  logic [SECT_N-1:0] wen_q = PROT_INIT;

  always_ff @(posedge clk) begin
    if (load) wen_q <= wen_in;
  end

  assign wen = wen_q;
endmodule

// File: rtl/dpw_plane.sv
// One plane: page buffer, drain sequencer, array storage and toggle status.
module dpw_plane
  import dpw_pkg::*;
#(
  parameter int PLANE_ID = 0,
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 5,
  parameter int SECT_N   = 8,
  parameter int T_PROG   = 40,
  parameter int TOG_BIT  = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_en,
  input  logic [ADDR_W-2:0]   ld_off,
  input  logic [DATA_W-1:0]   ld_data,
  input  logic                commit,
  input  logic [SECT_N-1:0]   lock,
  input  logic                rd_en,
  input  logic [ADDR_W-2:0]   rd_off,
  output logic                busy,
  output logic                we,
  output logic [ADDR_W-1:0]   waddr,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rd_q
);
  localparam int PLANE_AW = ADDR_W - 1;
  localparam int PG_N     = 1 << PAGE_W;
  localparam int PGID_W   = PLANE_AW - PAGE_W;
  localparam int SECT_W   = $clog2(SECT_N);
  localparam int CNT_W    = $clog2(T_PROG);
  localparam int MEM_N    = 1 << PLANE_AW;
  localparam logic PID    = 1'(PLANE_ID);

  pl_state_t            st;
  logic [CNT_W-1:0]     cnt;
  logic [PGID_W-1:0]    page_q;
  logic [PG_N-1:0]      vld;
  logic [DATA_W-1:0]    buf_q [PG_N];
  logic                 tog;
  logic                 stat_sel;
  logic [DATA_W-1:0]    mem_q;
  logic                 we_q;
  logic [ADDR_W-1:0]    waddr_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [DATA_W-1:0]    mem [MEM_N];

  logic [PGID_W-1:0]    ld_page;
  logic [PAGE_W-1:0]    ld_slot;
  logic                 ld_take;
  logic [PAGE_W-1:0]    slot;
  logic                 in_drain;
  logic [SECT_W-1:0]    sect;
  logic                 we_next;
  logic [DATA_W-1:0]    stat_word;

  initial begin
    for (int i = 0; i < MEM_N; i++) mem[i] = '1;
  end

  assign ld_page = ld_off[PLANE_AW-1:PAGE_W];
  assign ld_slot = ld_off[PAGE_W-1:0];
  assign busy    = (st == PL_PROG);

  // a byte enters the buffer when it opens a load or hits the open page
  always_comb begin
    ld_take = 1'b0;
    if (ld_en) begin
      if (st == PL_IDLE) ld_take = 1'b1;
      else if (st == PL_LOAD && ld_page == page_q) ld_take = 1'b1;
    end
  end

  // drain: slot index follows the cycle counter during the first PG_N cycles
  always_comb begin
    slot     = cnt[PAGE_W-1:0];
    in_drain = (st == PL_PROG) && (cnt < CNT_W'(PG_N));
    sect     = {PID, page_q[PGID_W-1 -: SECT_W-1]};
    we_next  = in_drain && vld[slot] && lock[sect];
  end

  always_ff @(posedge clk) begin
    if (ld_take) buf_q[ld_slot] <= ld_data;
  end

  // array storage: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we_next) mem[{page_q, slot}] <= buf_q[slot];
    if (rd_en)   mem_q <= mem[rd_off];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= PL_IDLE;
      cnt      <= '0;
      page_q   <= '0;
      vld      <= '0;
      tog      <= 1'b0;
      stat_sel <= 1'b0;
      we_q     <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      we_q <= we_next;
      if (we_next) begin
        waddr_q <= {PID, page_q, slot};
        wdata_q <= buf_q[slot];
      end
      if (rd_en) begin
        stat_sel <= busy;
        if (busy) tog <= ~tog;
      end
      case (st)
        PL_IDLE: begin
          if (ld_en) begin
            st     <= PL_LOAD;
            page_q <= ld_page;
            vld    <= PG_N'(1) << ld_slot;
          end
        end
        PL_LOAD: begin
          if (ld_take) vld[ld_slot] <= 1'b1;
          if (commit) begin
            st  <= PL_PROG;
            cnt <= '0;
          end
        end
        PL_PROG: begin
          if (cnt == CNT_W'(T_PROG - 1)) st <= PL_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: st <= PL_IDLE;
      endcase
    end
  end

  always_comb begin
    stat_word          = '0;
    stat_word[TOG_BIT] = tog;
  end

  assign rd_q  = stat_sel ? stat_word : mem_q;
  assign we    = we_q;
  assign waddr = waddr_q;
  assign wdata = wdata_q;

  AST_STROBE_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
    we_q |-> busy); // R5
  AST_LOCK_RESPECT: assert property (@(posedge clk) disable iff (rst)
    we_q |-> (($past(lock) & (SECT_N'(1) << waddr_q[ADDR_W-1 -: SECT_W])) != '0)); // R6
  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(commit)); // R4
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy) |=> (tog != $past(tog))); // R8
  AST_DROP_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && ld_en) |=> $stable(vld)); // R9
endmodule

// File: rtl/dpw_ctrl.sv
module dpw_ctrl #(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int PAGE_W  = 5,
  parameter int SECT_N  = 8,
  parameter int T_PROG  = 40,
  parameter int TOG_BIT = 6,
  parameter logic [SECT_N-1:0] PROT_INIT = '1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_req,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          wc,
  input  logic                          rd_req,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          rd_valid,
  input  logic                          prot_load,
  input  logic [SECT_N-1:0]             prot_wen,
  output logic [1:0]                    busy,
  output logic [1:0]                    arr_we,
  output logic [1:0][ADDR_W-1:0]        arr_waddr,
  output logic [1:0][DATA_W-1:0]        arr_wdata
);
  localparam int NPL = 2;

  logic [SECT_N-1:0] lock_vec;
  logic [DATA_W-1:0] pl_rdq [NPL];
  logic              rd_pl_q;
  logic              rd_valid_q;

  dpw_lock #(.SECT_N(SECT_N), .PROT_INIT(PROT_INIT)) u_lock (
    .clk    (clk),
    .load   (prot_load),
    .wen_in (prot_wen),
    .wen    (lock_vec)
  );

  for (genvar p = 0; p < NPL; p++) begin : g_plane
    dpw_plane #(
      .PLANE_ID (p),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .PAGE_W   (PAGE_W),
      .SECT_N   (SECT_N),
      .T_PROG   (T_PROG),
      .TOG_BIT  (TOG_BIT)
    ) u_plane (
      .clk     (clk),
      .rst     (rst),
      .ld_en   (wr_req && (wr_addr[ADDR_W-1] == 1'(p))),
      .ld_off  (wr_addr[ADDR_W-2:0]),
      .ld_data (wr_data),
      .commit  (wc),
      .lock    (lock_vec),
      .rd_en   (rd_req && (rd_addr[ADDR_W-1] == 1'(p))),
      .rd_off  (rd_addr[ADDR_W-2:0]),
      .busy    (busy[p]),
      .we      (arr_we[p]),
      .waddr   (arr_waddr[p]),
      .wdata   (arr_wdata[p]),
      .rd_q    (pl_rdq[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_pl_q    <= 1'b0;
    end else begin
      rd_valid_q <= rd_req;
      if (rd_req) rd_pl_q <= rd_addr[ADDR_W-1];
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_pl_q ? pl_rdq[1] : pl_rdq[0];

  AST_RD_ANSWER: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid); // R1
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(prot_load) |-> $stable(lock_vec)); // R7
  AST_STROBE_PLANE: assert property (@(posedge clk) disable iff (rst)
    arr_we[1] |-> arr_waddr[1][ADDR_W-1]); // R1
endmodule

// File: tb/dpw_ctrl_tb.sv
`timescale 1ns/1ps
module dpw_ctrl_tb;
  localparam int TP = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_req = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        wc = 1'b0;
  logic        rd_req = 1'b0;
  logic [12:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        prot_load = 1'b0;
  logic [7:0]  prot_wen = '0;
  logic [1:0]  busy;
  logic [1:0]  arr_we;
  logic [1:0][12:0] arr_waddr;
  logic [1:0][7:0]  arr_wdata;

  int n_chk = 0;
  int n_fail = 0;
  int n_stb = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dpw_ctrl #(.T_PROG(TP)) u_dut (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wc(wc), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .prot_load(prot_load), .prot_wen(prot_wen),
    .busy(busy), .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  int   m_st [2];
  int   m_cnt [2];
  int   m_page [2];
  bit   m_vld [2][32];
  logic [7:0] m_buf [2][32];
  bit   m_tog [2];
  logic [7:0] m_mem [8192];
  logic [7:0] m_lock = 8'hFF;
  bit   e_busy [2];
  bit   e_we [2];
  int   e_waddr [2];
  logic [7:0] e_wdata [2];
  bit   e_rdv;
  logic [7:0] e_rdata;
  bit   m_rst_s = 1'b1;

  initial begin
    for (int i = 0; i < 8192; i++) m_mem[i] = 8'hFF;
    for (int p = 0; p < 2; p++) begin
      m_st[p] = 0; m_cnt[p] = 0; m_tog[p] = 0; e_busy[p] = 0; e_we[p] = 0;
    end
    e_rdv = 0;
  end

  always @(posedge clk) begin
    m_rst_s = rst;
    if (rst) begin
      for (int p = 0; p < 2; p++) begin
        m_st[p] = 0; m_tog[p] = 0; e_busy[p] = 0; e_we[p] = 0;
      end
      e_rdv = 0;
    end else begin
      e_rdv = rd_req;
      if (rd_req) begin
        int q;
        q = int'(rd_addr[12]);
        if (m_st[q] == 2) begin
          m_tog[q] = !m_tog[q];
          e_rdata = m_tog[q] ? 8'h40 : 8'h00;
        end else e_rdata = m_mem[int'(rd_addr)];
      end
      for (int p = 0; p < 2; p++) begin
        e_we[p] = 0;
        if (m_st[p] == 2 && m_cnt[p] < 32) begin
          int a;
          a = p * 4096 + m_page[p] * 32 + m_cnt[p];
          if (m_vld[p][m_cnt[p]] && m_lock[a / 1024]) begin
            e_we[p] = 1; e_waddr[p] = a; e_wdata[p] = m_buf[p][m_cnt[p]];
            m_mem[a] = m_buf[p][m_cnt[p]];
          end
        end
      end
      for (int p = 0; p < 2; p++) begin
        bit hit;
        hit = wr_req && (int'(wr_addr[12]) == p);
        if (m_st[p] == 0) begin
          if (hit) begin
            m_st[p] = 1; m_page[p] = int'(wr_addr[11:5]);
            for (int s = 0; s < 32; s++) m_vld[p][s] = 0;
            m_vld[p][int'(wr_addr[4:0])] = 1;
            m_buf[p][int'(wr_addr[4:0])] = wr_data;
          end
        end else if (m_st[p] == 1) begin
          if (hit && int'(wr_addr[11:5]) == m_page[p]) begin
            m_vld[p][int'(wr_addr[4:0])] = 1;
            m_buf[p][int'(wr_addr[4:0])] = wr_data;
          end
          if (wc) begin m_st[p] = 2; m_cnt[p] = 0; end
        end else begin
          if (m_cnt[p] == TP - 1) m_st[p] = 0;
          else m_cnt[p]++;
        end
        e_busy[p] = (m_st[p] == 2);
      end
      if (prot_load) m_lock = prot_wen;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!m_rst_s) begin
      check(busy == {e_busy[1], e_busy[0]}, "R4 busy", busy, {e_busy[1], e_busy[0]});
      check(arr_we == {e_we[1], e_we[0]}, "R5 strobe", arr_we, {e_we[1], e_we[0]});
      for (int p = 0; p < 2; p++) if (e_we[p]) begin
        check(int'(arr_waddr[p]) == e_waddr[p], "R6 waddr", arr_waddr[p], e_waddr[p]);
        check(arr_wdata[p] == e_wdata[p], "R3 wdata", arr_wdata[p], e_wdata[p]);
      end
      check(rd_valid == e_rdv, "R1 rd_valid", rd_valid, e_rdv);
      if (e_rdv) check(rd_data == e_rdata, "R8 rd_data", rd_data, e_rdata);
    end
    n_stb += int'(arr_we[0]) + int'(arr_we[1]);
  end

  task automatic wr(int a, int d);
    wr_req = 1; wr_addr = 13'(a); wr_data = 8'(d);
    @(negedge clk); wr_req = 0;
  endtask

  task automatic pulse_wc();
    wc = 1; @(negedge clk); wc = 0;
  endtask

  task automatic rdchk(int a, int exp, string tag);
    rd_req = 1; rd_addr = 13'(a);
    @(negedge clk); rd_req = 0;
    check(rd_data == 8'(exp), tag, rd_data, exp);
  endtask

  task automatic set_lock(int v);
    prot_load = 1; prot_wen = 8'(v);
    @(negedge clk); prot_load = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 2'b00 && arr_we == 2'b00 && rd_valid == 1'b0, "R11 reset", {busy, arr_we, rd_valid}, 0);
    rst = 0;
    @(negedge clk);
    rdchk(13'h0010, 8'hFF, "R1 erased read");

    // page load with repeat slot and an out-of-page byte
    n_stb = 0;
    wr(13'h0040, 8'hA0); wr(13'h0041, 8'hA1); wr(13'h0042, 8'hA2);
    wr(13'h0043, 8'hA3); wr(13'h0041, 8'hB1); wr(13'h0060, 8'h55);
    pulse_wc();
    check(busy == 2'b01, "R4 busy after wc", busy, 1);
    rdchk(13'h0044, 8'h40, "R8 first poll");
    rdchk(13'h0044, 8'h00, "R8 second poll");
    rdchk(13'h1000, 8'hFF, "R2 other plane read");
    wr(13'h0050, 8'h77);
    repeat (TP) @(negedge clk);
    check(busy == 2'b00, "R4 busy ended", busy, 0);
    check(n_stb == 4, "R5 strobe count", n_stb, 4);
    rdchk(13'h0040, 8'hA0, "R3 slot0");
    rdchk(13'h0041, 8'hB1, "R3 last wins");
    rdchk(13'h0043, 8'hA3, "R3 slot3");
    rdchk(13'h0060, 8'hFF, "R3 out of page");
    rdchk(13'h0050, 8'hFF, "R9 dropped write");
    rdchk(13'h0042, 8'hA2, "R10 data after busy");

    // locked section 2 (addresses 0x0800..0x0BFF)
    set_lock(8'hFB);
    n_stb = 0;
    wr(13'h0805, 8'h11); pulse_wc();
    repeat (TP + 2) @(negedge clk);
    check(n_stb == 0, "R6 no strobe when locked", n_stb, 0);
    rdchk(13'h0805, 8'hFF, "R6 locked unchanged");
    wr(13'h0C01, 8'h22); pulse_wc();
    repeat (TP + 2) @(negedge clk);
    rdchk(13'h0C01, 8'h22, "R4 single byte write");

    // protection survives reset
    rst = 1; repeat (2) @(negedge clk); rst = 0; @(negedge clk);
    wr(13'h0806, 8'h33); pulse_wc();
    repeat (TP + 2) @(negedge clk);
    rdchk(13'h0806, 8'hFF, "R7 lock kept over reset");
    set_lock(8'hFF);
    wr(13'h0806, 8'h33); pulse_wc();
    repeat (TP + 2) @(negedge clk);
    rdchk(13'h0806, 8'h33, "R7 lock reloaded");

    // both planes closed by one wc pulse
    wr(13'h0100, 8'h44); wr(13'h1100, 8'h66); pulse_wc();
    check(busy == 2'b11, "R4 both planes busy", busy, 3);
    repeat (TP + 2) @(negedge clk);
    rdchk(13'h0100, 8'h44, "R1 plane0 data");
    rdchk(13'h1100, 8'h66, "R1 plane1 data");

    // reset discards an open load
    wr(13'h0200, 8'h77);
    rst = 1; repeat (2) @(negedge clk); rst = 0; @(negedge clk);
    pulse_wc();
    check(busy == 2'b00, "R11 load discarded", busy, 0);
    rdchk(13'h0200, 8'hFF, "R11 array unchanged");

    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule